// File: doc/BRIEF.md
# Mode-banked register file

This block holds the general registers of a processor core that switches between a user context and five privileged contexts. Sixteen registers are visible at any time. The fast-interrupt context has its own private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined contexts each have private copies of registers 13 and 14 only. Every privileged context also owns a saved-status register. The live status register carries the 5-bit mode field in bits [4:0], and that field selects which copies are visible.

The block does not copy data when the mode changes. It keeps one physical slot for every copy and routes the visible index to the slot of the active bank. The bank selection is a small state machine. Its states are BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT and BK_UND, and it resets into BK_SVC. It has two kinds of transition:
- **swap**: a status write or a restore lands a mode code that belongs to a different bank.
- **hold**: all other cycles, including a status write whose new code maps to the same bank.

A restore operation reloads the live status from the saved status of the current mode. A debug port reads any bank's copy of a register, or its saved status, by naming a mode code. Register 15 is not stored: reading it returns the program-counter value from the fetch unit.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status reads 0x000000D3 (supervisor, both interrupt masks set). Every saved-status register reads 0x00000010. Registers r0 to r14 read 0.
- R2: Reads on both read ports are combinational from the current bank. Index 15 returns `pc_in`. A write to index 0 to 14 is visible from the cycle after it is accepted.
- R3: In fast-interrupt mode (code 0x11), r8 to r14 map to private copies. Writes made there leave the user copies untouched, and the private values reappear on a later return to code 0x11.
- R4: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes have private r13 and r14 only. Their r0 to r12 are the same registers that user mode sees.
- R5: User (0x10), system (0x1F) and every other code not listed in R3 or R4 (for example 0x14) select the user copies of all registers.
- R6: A register write in the same cycle as a status write that changes the bank goes to the bank that was active before the change.
- R7: A restore copies the saved status of the current mode into the status, with bit 4 forced to 1. Codes 0x11, 0x12 and 0x13 use their own saved status, codes 0x14 to 0x17 use the abort one, and codes 0x18 to 0x1B use the undefined one. The new mode's bank is visible from the next cycle.
- R8: A restore in a mode with no saved status (0x10, 0x1F or any code outside R7) leaves the status unchanged. In that case `restore_err` is 1 for exactly the next cycle.
- R9: A saved-status write updates the saved status that a restore in the current mode would use. In a mode with no saved status it changes nothing.
- R10: The debug port decodes `dbg_mode` as in R3 to R5. With `dbg_idx` 0 to 14 it returns that bank's copy: the live value if that bank is active, the shadow copy otherwise. With index 15 it returns that bank's saved status, or 0 for the user bank.
- R11: When a restore and a status write arrive in the same cycle, the restore wins.
- R12: A status write whose mode code maps to the bank already active changes no visible register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index (15 is ignored) |
| wr_data | input | DW | Register write data |
| pc_in | input | DW | Pipelined program counter returned for index 15 |
| stat_we | input | 1 | Live status write strobe |
| stat_wdata | input | DW | Live status write value; bits [4:0] are the mode |
| sav_we | input | 1 | Saved-status write strobe for the current mode |
| sav_wdata | input | DW | Saved-status write value |
| restore_req | input | 1 | Reload status from the current mode's saved status |
| dbg_mode | input | 5 | Mode code selecting the bank for the debug read |
| dbg_idx | input | 4 | Debug register index; 15 selects the saved status |
| dbg_data | output | DW | Debug read data |
| status_o | output | DW | Live status register |
| restore_err | output | 1 | One-cycle flag for a restore with no saved status |

## Verification
A wrong bank state is visible on the read ports in the same cycle the status changes. A swap into the wrong bank shows up as r8 to r14 returning another context's values on the first read after the mode switch. A slot mix-up shows up in the debug port as a shadow copy that equals the live one, or as a live copy that differs from the same index on the visible port. Restore faults show up on `status_o` one cycle after the request: a wrong saved-status pick, bit 4 left clear, or an error case that still alters the status. A register write routed to the post-swap bank is exposed by the first read after returning to the mode that should have received it.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    localparam int NVIS    = 16;
    localparam int FIQ_LO  = 8;
    localparam int PRIV_LO = 13;
    localparam int PC_IDX  = NVIS - 1;
    localparam int MID_N   = PRIV_LO - FIQ_LO;
    localparam int TAIL_N  = PC_IDX - PRIV_LO;
    localparam int SH_W    = $clog2(FIQ_LO);
    localparam int MID_W   = $clog2(MID_N);
    localparam int TAIL_W  = (TAIL_N > 1) ? $clog2(TAIL_N) : 1;
    localparam int NBANK   = 6;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic  ok;
        bank_e bank;
    } save_sel_t;

    // Register bank selected by a mode code: only exact privileged codes swap.
    function automatic bank_e reg_bank(input logic [4:0] m);
        bank_e b;
        unique case (m)
            M_FIQ:   b = BK_FIQ;
            M_IRQ:   b = BK_IRQ;
            M_SVC:   b = BK_SVC;
            M_ABT:   b = BK_ABT;
            M_UND:   b = BK_UND;
            default: b = BK_USR;
        endcase
        return b;
    endfunction

    // Saved-status bank used by restore and saved-status writes.
    function automatic save_sel_t save_bank(input logic [4:0] m);
        save_sel_t s;
        unique case (m)
            5'h11:                      s = '{ok: 1'b1, bank: BK_FIQ};
            5'h12:                      s = '{ok: 1'b1, bank: BK_IRQ};
            5'h13:                      s = '{ok: 1'b1, bank: BK_SVC};
            5'h14, 5'h15, 5'h16, 5'h17: s = '{ok: 1'b1, bank: BK_ABT};
            5'h18, 5'h19, 5'h1A, 5'h1B: s = '{ok: 1'b1, bank: BK_UND};
            default:                    s = '{ok: 1'b0, bank: BK_USR};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/banked_regfile_mode.sv
module banked_regfile_mode
    import banked_regfile_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_we,
    input  logic [DW-1:0] stat_wdata,
    input  logic          restore_req,
    input  logic [DW-1:0] sav_cur,
    output logic [DW-1:0] status_q,
    output bank_e         bank_q,
    output bank_e         sav_bank,
    output logic          sav_ok,
    output logic          restore_err
);

    localparam logic [DW-1:0] STAT_RST = DW'(8'hD3);

    logic [DW-1:0] status_n;
    bank_e         bank_n;
    logic          err_n;
    save_sel_t     cur_sel;

    // Next state: restore has priority over a plain status write.
    always_comb begin
        status_n = status_q;
        err_n    = 1'b0;
        if (restore_req) begin
            if (sav_ok) begin
                status_n    = sav_cur;
                status_n[4] = 1'b1;
            end else begin
                err_n = 1'b1;
            end
        end else if (stat_we) begin
            status_n = stat_wdata;
        end
        bank_n = reg_bank(status_n[4:0]);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q    <= STAT_RST;
            bank_q      <= BK_SVC;
            restore_err <= 1'b0;
        end else begin
            status_q    <= status_n;
            bank_q      <= bank_n;
            restore_err <= err_n;
        end
    end

    // Outputs: saved-status selection for the current mode.
    always_comb begin
        cur_sel  = save_bank(status_q[4:0]);
        sav_ok   = cur_sel.ok;
        sav_bank = cur_sel.bank;
    end

    // R7
    restore_bit4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && sav_ok) |=> status_q[4]);

    // R8
    restore_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !sav_ok) |=> ($stable(status_q) && restore_err));

    // R11
    restore_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && sav_ok && stat_we) |=> (status_q[3:0] == $past(sav_cur[3:0])));

    // R12
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_req && (!stat_we || (reg_bank(stat_wdata[4:0]) == bank_q))) |=> $stable(bank_q));

endmodule

// File: rtl/banked_regfile_store.sv
module banked_regfile_store
    import banked_regfile_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NRD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         vis_bank,
    input  bank_e         sav_bank,
    input  logic          sav_ok,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          sav_we,
    input  logic [DW-1:0] sav_wdata,
    input  logic [3:0]    rd_idx  [NRD],
    output logic [DW-1:0] rd_data [NRD],
    input  logic [DW-1:0] pc_in,
    input  bank_e         dbg_bank,
    input  logic [3:0]    dbg_idx,
    output logic [DW-1:0] dbg_data,
    output logic [DW-1:0] sav_cur
);

    localparam logic [DW-1:0] SAV_RST = DW'(8'h10);

    logic [DW-1:0] shared_q [FIQ_LO];
    logic [DW-1:0] mid_q    [2][MID_N];
    logic [DW-1:0] tail_q   [NBANK][TAIL_N];
    logic [DW-1:0] sav_q    [NBANK];

    function automatic logic [DW-1:0] pick(input bank_e b, input logic [3:0] i);
        logic [3:0] om;
        logic [3:0] ot;
        om = i - 4'(FIQ_LO);
        ot = i - 4'(PRIV_LO);
        if (i == 4'(PC_IDX))  return pc_in;
        if (i < 4'(FIQ_LO))   return shared_q[i[SH_W-1:0]];
        if (i < 4'(PRIV_LO))  return mid_q[b == BK_FIQ][om[MID_W-1:0]];
        return tail_q[b][ot[TAIL_W-1:0]];
    endfunction

    logic [3:0] w_om;
    logic [3:0] w_ot;
    always_comb begin
        w_om = wr_idx - 4'(FIQ_LO);
        w_ot = wr_idx - 4'(PRIV_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < FIQ_LO; k++) shared_q[k] <= '0;
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < MID_N; k++) mid_q[s][k] <= '0;
            for (int b = 0; b < NBANK; b++) begin
                for (int k = 0; k < TAIL_N; k++) tail_q[b][k] <= '0;
                sav_q[b] <= SAV_RST;
            end
        end else begin
            if (wr_en && (wr_idx != 4'(PC_IDX))) begin
                if (wr_idx < 4'(FIQ_LO))
                    shared_q[wr_idx[SH_W-1:0]] <= wr_data;
                else if (wr_idx < 4'(PRIV_LO))
                    mid_q[vis_bank == BK_FIQ][w_om[MID_W-1:0]] <= wr_data;
                else
                    tail_q[vis_bank][w_ot[TAIL_W-1:0]] <= wr_data;
            end
            if (sav_we && sav_ok)
                sav_q[sav_bank] <= sav_wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = pick(vis_bank, rd_idx[g]);
    end

    always_comb begin
        if (dbg_idx == 4'(PC_IDX))
            dbg_data = (dbg_bank == BK_USR) ? '0 : sav_q[dbg_bank];
        else
            dbg_data = pick(dbg_bank, dbg_idx);
    end

    assign sav_cur = sav_q[sav_bank];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] pc_in,
    input  logic          stat_we,
    input  logic [DW-1:0] stat_wdata,
    input  logic          sav_we,
    input  logic [DW-1:0] sav_wdata,
    input  logic          restore_req,
    input  logic [4:0]    dbg_mode,
    input  logic [3:0]    dbg_idx,
    output logic [DW-1:0] dbg_data,
    output logic [DW-1:0] status_o,
    output logic          restore_err
);

    localparam int NRD = 2;

    bank_e         vis_bank;
    bank_e         sav_bank;
    bank_e         dbg_bank;
    logic          sav_ok;
    logic [DW-1:0] sav_cur;
    logic [3:0]    rd_idx  [NRD];
    logic [DW-1:0] rd_data [NRD];

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign dbg_bank  = reg_bank(dbg_mode);

    banked_regfile_mode #(.DW(DW)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_we     (stat_we),
        .stat_wdata  (stat_wdata),
        .restore_req (restore_req),
        .sav_cur     (sav_cur),
        .status_q    (status_o),
        .bank_q      (vis_bank),
        .sav_bank    (sav_bank),
        .sav_ok      (sav_ok),
        .restore_err (restore_err)
    );

    banked_regfile_store #(.DW(DW), .NRD(NRD)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .vis_bank  (vis_bank),
        .sav_bank  (sav_bank),
        .sav_ok    (sav_ok),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sav_we    (sav_we),
        .sav_wdata (sav_wdata),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .pc_in     (pc_in),
        .dbg_bank  (dbg_bank),
        .dbg_idx   (dbg_idx),
        .dbg_data  (dbg_data),
        .sav_cur   (sav_cur)
    );

    // R10
    dbg_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dbg_mode == status_o[4:0]) && (dbg_idx == rd_a_idx) && (dbg_idx != 4'hF))
        |-> (dbg_data == rd_a_data));

endmodule

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, dbg_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, dbg_data, status_o;
    logic [31:0] wr_data = '0, stat_wdata = '0, sav_wdata = '0;
    logic [31:0] pc_in = 32'h1234_5678;
    logic        wr_en = 1'b0, stat_we = 1'b0, sav_we = 1'b0, restore_req = 1'b0;
    logic [4:0]  dbg_mode = 5'h10;
    logic        restore_err;

    always #2.5 clk = ~clk;

    banked_regfile #(.DW(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_in(pc_in),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .sav_we(sav_we), .sav_wdata(sav_wdata),
        .restore_req(restore_req),
        .dbg_mode(dbg_mode), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .status_o(status_o), .restore_err(restore_err)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [7:0]  req;
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];
    item_t it;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    logic [31:0] act;

    // Monitor: pops expected items and compares away from the rising edge.
    always @(negedge clk) begin
        while (sbq.size() != 0) begin
            it = sbq.pop_front();
            case (it.sel)
                3'd0:    act = rd_a_data;
                3'd1:    act = rd_b_data;
                3'd2:    act = dbg_data;
                3'd3:    act = status_o;
                default: act = {31'd0, restore_err};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; stat_we = 1'b0; sav_we = 1'b0; restore_req = 1'b0;
    endtask

    task automatic push(input logic [2:0] sel, input int req, input logic [31:0] exp);
        sbq.push_back('{sel: sel, req: 8'(req), exp: exp});
        @(negedge clk);
        #1;
    endtask

    task automatic look_a(input logic [3:0] i, input logic [31:0] e, input int req);
        rd_a_idx = i; push(3'd0, req, e);
    endtask
    task automatic look_b(input logic [3:0] i, input logic [31:0] e, input int req);
        rd_b_idx = i; push(3'd1, req, e);
    endtask
    task automatic look_dbg(input logic [4:0] m, input logic [3:0] i, input logic [31:0] e, input int req);
        dbg_mode = m; dbg_idx = i; push(3'd2, req, e);
    endtask
    task automatic look_stat(input logic [31:0] e, input int req);
        push(3'd3, req, e);
    endtask
    task automatic look_err(input logic e, input int req);
        push(3'd4, req, {31'd0, e});
    endtask

    task automatic do_wr(input logic [3:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d; tick();
    endtask
    task automatic do_stat(input logic [31:0] v);
        stat_we = 1'b1; stat_wdata = v; tick();
    endtask
    task automatic do_sav(input logic [31:0] v);
        sav_we = 1'b1; sav_wdata = v; tick();
    endtask
    task automatic do_restore();
        restore_req = 1'b1; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        look_stat(32'h0000_00D3, 1);
        look_dbg(5'h11, 4'd15, 32'h10, 1);
        look_dbg(5'h12, 4'd15, 32'h10, 1);
        look_dbg(5'h13, 4'd15, 32'h10, 1);
        look_dbg(5'h17, 4'd15, 32'h10, 1);
        look_dbg(5'h1B, 4'd15, 32'h10, 1);
        look_a(4'd0, 32'h0, 1);
        look_b(4'd13, 32'h0, 1);
        // R2 program counter and write-then-read
        look_a(4'd15, 32'h1234_5678, 2);
        do_wr(4'd13, 32'h5C13);
        do_wr(4'd14, 32'h5C14);
        do_wr(4'd8, 32'h88);
        do_wr(4'd0, 32'hA0);
        look_a(4'd13, 32'h5C13, 2);
        look_b(4'd8, 32'h88, 2);
        // R4 supervisor banks only r13/r14
        do_stat(32'h10);
        look_a(4'd13, 32'h0, 4);
        look_b(4'd8, 32'h88, 4);
        look_a(4'd0, 32'hA0, 4);
        look_dbg(5'h13, 4'd13, 32'h5C13, 10);   // R10 shadow copy
        look_dbg(5'h13, 4'd14, 32'h5C14, 10);
        do_wr(4'd13, 32'h0513);
        do_wr(4'd8, 32'h0508);
        // R3 fast-interrupt private r8-r14
        do_stat(32'h11);
        look_a(4'd8, 32'h0, 3);
        look_b(4'd13, 32'h0, 3);
        look_a(4'd0, 32'hA0, 3);
        do_wr(4'd8, 32'hF8);
        do_wr(4'd12, 32'hFC);
        do_wr(4'd14, 32'hFE);
        look_a(4'd14, 32'hFE, 3);
        look_dbg(5'h10, 4'd8, 32'h0508, 10);    // R10 shadow of user
        look_dbg(5'h11, 4'd8, 32'hF8, 10);      // R10 live copy
        look_dbg(5'h1F, 4'd12, 32'h0, 10);
        // R6 write in the same cycle as a mode change
        stat_we = 1'b1; stat_wdata = 32'h1F; wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h99;
        tick();
        look_a(4'd9, 32'h0, 6);
        look_dbg(5'h11, 4'd9, 32'h99, 6);
        // R5 system shares user bank
        look_a(4'd8, 32'h0508, 5);
        look_b(4'd13, 32'h0513, 5);
        look_a(4'd14, 32'h0, 5);
        do_stat(32'h14);
        look_a(4'd13, 32'h0513, 5);
        // R9 saved-status write in code 0x14 goes to abort bank
        do_sav(32'h6000_0002);
        look_dbg(5'h17, 4'd15, 32'h6000_0002, 9);
        look_dbg(5'h14, 4'd15, 32'h0, 10);
        // R7 restore through abort bank, bit 4 forced
        do_restore();
        look_stat(32'h6000_0012, 7);
        look_err(1'b0, 7);
        look_a(4'd13, 32'h0, 7);
        look_b(4'd8, 32'h0508, 4);
        do_wr(4'd13, 32'h1A13);
        do_restore();
        look_stat(32'h10, 7);
        look_a(4'd13, 32'h0513, 7);
        look_dbg(5'h12, 4'd13, 32'h1A13, 10);
        // R8 restore with no saved status
        do_restore();
        look_err(1'b1, 8);
        look_stat(32'h10, 8);
        tick();
        look_err(1'b0, 8);
        // R9 saved-status write ignored in user mode
        do_sav(32'hDEAD_BEEF);
        look_dbg(5'h11, 4'd15, 32'h10, 9);
        look_dbg(5'h12, 4'd15, 32'h10, 9);
        look_dbg(5'h13, 4'd15, 32'h10, 9);
        look_dbg(5'h1B, 4'd15, 32'h10, 9);
        look_dbg(5'h17, 4'd15, 32'h6000_0002, 9);
        // R11 restore beats a status write
        do_stat(32'h1B);
        do_sav(32'h2000_0001);
        stat_we = 1'b1; stat_wdata = 32'h13; restore_req = 1'b1;
        tick();
        look_stat(32'h2000_0011, 11);
        look_a(4'd8, 32'hF8, 3);
        look_b(4'd12, 32'hFC, 3);
        look_a(4'd14, 32'hFE, 3);
        look_b(4'd13, 32'h0, 3);
        // R12 same-bank status write keeps registers
        do_stat(32'hD1);
        look_stat(32'hD1, 12);
        look_a(4'd8, 32'hF8, 12);
        look_b(4'd9, 32'h99, 12);
        // R8 in system mode
        do_stat(32'h1F);
        do_restore();
        look_err(1'b1, 8);
        look_stat(32'h1F, 8);
        tick();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule